// File: doc/BRIEF.md
# Nine-Level Stacked-Carrier PWM Modulator

This block produces the eight gate commands for one leg of an asymmetric nine-level converter. The leg has two capacitors, one charged to three times the voltage of the other. A signed modulation sample from the current controller is compared against eight triangular carriers. The carriers share one phase and sit on top of one another, each covering one eighth of the sample range. The number of carriers that the sample exceeds picks an output level between 1 and 9. A fixed table then turns that level into three active switches out of eight.

Every switch pair that is toggled in a complementary way goes through a dead-time stage. When one switch of the pair hands over to the other, both stay off for a programmable number of clocks. A fault input clears all gates on the next clock. The current level is also brought out so that capacitor-balancing logic can follow it. The modulation sample is taken only at the carrier peak, so a level decision never mixes two samples inside one carrier period. With the default divider and a 100 MHz clock, the carrier runs at close to 10 kHz.

Top module: `ml9_pwm_mod`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `gate_o` is 0 after that edge and `level_o` is 5. The triangle restarts at 0 and counts upward.
- R2: Let u be the sample in offset binary, u = `mod_i` + 2^(SW-1), and let BAND = 2^SW/8. Let t be the triangle value. `level_o` equals 1 plus the number of k in 0..7 for which u > k*BAND + t.
- R3: The triangle t moves by one every PRESCALE clocks. It rises from 0 to BAND and then falls back to 1, so one carrier period lasts 2*BAND*PRESCALE clocks.
- R4: `mod_i` is captured only when t leaves its peak value BAND. Changes to `mod_i` at any other time leave `level_o` unchanged until that capture.
- R5: `gate_o` bit i-1 drives switch i. After the level has been steady long enough, the gates show these sets of active switches, with all others off: level 9 → 1,6,8; level 8 → 1,4,6; level 7 → 1,4,5; level 6 → 1,3,6; level 5 → 1,3,5; level 4 → 2,4,5; level 3 → 2,3,6; level 2 → 2,3,5; level 1 → 2,5,7.
- R6: Switches 1 and 2 are never on together, and neither are switches 5 and 6. No more than three gates are ever on at once.
- R7: The pairs are (1,2), (3,4), (5,6) and (7,8). When the target of a pair changes while one of its switches is on, both switches of the pair stay off for exactly `dead_cyc_i`+1 clocks, provided the target does not change again in that time. No switch ever turns on in the clock right after its partner was on.
- R8: If `fault_i` is high at a rising edge, `gate_o` is 0 after that edge. When the fault clears, the gates return to the pattern for the current level.
- R9: `level_o` always stays within 1..9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fault_i | input | 1 | Forces all gates off from the next edge |
| dead_cyc_i | input | DT_W | Dead time per pair hand-over, in clocks minus one |
| mod_i | input | SW | Signed modulation sample |
| gate_o | output | 8 | Gate commands, bit i-1 = switch i |
| level_o | output | 4 | Current output level 1..9 |

## Verification
A level change and a dead-time countdown overlap whenever the sample sits between levels 4 and 5. In that case the pair (1,2) hands over on every carrier crossing, while the level keeps moving on the next triangle step. The bench measures each off-gap of that pair against `dead_cyc_i`+1. It also checks the gate pattern only after the level has held for longer than the countdown. A fault can also arrive in the middle of a countdown. The bench sets the dead time while a fault is held and pulses the fault during modulation. Off-gaps that a fault touched are excluded from the exact-length rule, but the fault still has to clear every gate on the next clock.

// File: rtl/ml9_pkg.sv
package ml9_pkg;
  localparam int NUM_SW  = 8;
  localparam int NUM_CAR = 8;
  localparam int LVL_W   = 4;

  // gate mask for a level: bit i-1 is switch i
  function automatic logic [NUM_SW-1:0] ml9_pattern(input logic [LVL_W-1:0] lvl);
    logic [NUM_SW-1:0] m;
    case (lvl)
      4'd9:    m = 8'b1010_0001;
      4'd8:    m = 8'b0010_1001;
      4'd7:    m = 8'b0001_1001;
      4'd6:    m = 8'b0010_0101;
      4'd5:    m = 8'b0001_0101;
      4'd4:    m = 8'b0001_1010;
      4'd3:    m = 8'b0010_0110;
      4'd2:    m = 8'b0001_0110;
      4'd1:    m = 8'b0101_0010;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ml9_carrier.sv
module ml9_carrier #(
  parameter int SW       = 8,
  parameter int PRESCALE = 156
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic [SW-1:0]                 mod_i,
  output logic [$clog2((1<<SW)/8+1)-1:0] tri_cnt_o,
  output logic [SW-1:0]                 mod_u_o
);
  localparam int BAND = (1 << SW) / 8;
  localparam int TW   = $clog2(BAND + 1);
  localparam int PW   = $clog2(PRESCALE + 1);

  logic [PW-1:0] div_q;
  logic          tick;
  logic          up_q;
  logic [TW-1:0] tri_q;

  assign tick = (div_q == PW'(PRESCALE - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q   <= '0;
      tri_q   <= '0;
      up_q    <= 1'b1;
      mod_u_o <= {1'b1, {(SW-1){1'b0}}};
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (tri_q == TW'(BAND)) begin
          // peak: take a new sample in offset binary
          mod_u_o <= {~mod_i[SW-1], mod_i[SW-2:0]};
        end
        if (up_q) begin
          tri_q <= tri_q + 1'b1;
          if (tri_q == TW'(BAND - 1)) up_q <= 1'b0;
        end else begin
          tri_q <= tri_q - 1'b1;
          if (tri_q == TW'(1)) up_q <= 1'b1;
        end
      end
    end
  end

  assign tri_cnt_o = tri_q;
endmodule

// File: rtl/ml9_level.sv
module ml9_level
  import ml9_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic [$clog2((1<<SW)/8+1)-1:0] tri_cnt_i,
  input  logic [SW-1:0]                 mod_u_i,
  output logic [LVL_W-1:0]              level_o
);
  localparam int BAND = (1 << SW) / 8;

  logic [NUM_CAR-1:0] above;
  logic [LVL_W-1:0]   cnt;

  generate
    for (genvar k = 0; k < NUM_CAR; k++) begin : g_car
      logic [SW:0] thr;
      assign thr      = (SW+1)'(k * BAND) + (SW+1)'(tri_cnt_i);
      assign above[k] = ({1'b0, mod_u_i} > thr);
    end
  endgenerate

  always_comb begin
    cnt = LVL_W'(1);
    for (int k = 0; k < NUM_CAR; k++) begin
      cnt = cnt + LVL_W'(above[k]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) level_o <= LVL_W'(5);
    else       level_o <= cnt;
  end
endmodule

// File: rtl/ml9_deadtime.sv
module ml9_deadtime
  import ml9_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              fault_i,
  input  logic [DT_W-1:0]   dead_cyc_i,
  input  logic [NUM_SW-1:0] target_i,
  output logic [NUM_SW-1:0] gate_o
);
  localparam int NPAIR = NUM_SW / 2;

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic [1:0]      app_q;
      logic [DT_W-1:0] wait_q;
      logic [1:0]      tgt;
      assign tgt = target_i[2*p +: 2];

      always_ff @(posedge clk_i) begin
        if (rst_i || fault_i) begin
          app_q  <= 2'b00;
          wait_q <= '0;
        end else if (app_q != 2'b00 && app_q != tgt) begin
          app_q  <= 2'b00;
          wait_q <= dead_cyc_i;
        end else if (wait_q != '0) begin
          wait_q <= wait_q - 1'b1;
        end else begin
          app_q <= tgt;
        end
      end

      assign gate_o[2*p +: 2] = app_q;
    end
  endgenerate
endmodule

// File: rtl/ml9_pwm_mod.sv
module ml9_pwm_mod
  import ml9_pkg::*;
#(
  parameter int SW       = 8,
  parameter int PRESCALE = 156,
  parameter int DT_W     = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            fault_i,
  input  logic [DT_W-1:0] dead_cyc_i,
  input  logic [SW-1:0]   mod_i,
  output logic [7:0]      gate_o,
  output logic [3:0]      level_o
);
  localparam int BAND = (1 << SW) / 8;
  localparam int TW   = $clog2(BAND + 1);

  logic [TW-1:0]     tri_cnt;
  logic [SW-1:0]     mod_u;
  logic [LVL_W-1:0]  lvl_q;
  logic [NUM_SW-1:0] sw_tgt;

  ml9_carrier #(.SW(SW), .PRESCALE(PRESCALE)) car_i (
    .clk_i(clk_i), .rst_i(rst_i), .mod_i(mod_i),
    .tri_cnt_o(tri_cnt), .mod_u_o(mod_u)
  );

  ml9_level #(.SW(SW)) lvl_i (
    .clk_i(clk_i), .rst_i(rst_i), .tri_cnt_i(tri_cnt),
    .mod_u_i(mod_u), .level_o(lvl_q)
  );

  assign sw_tgt = ml9_pattern(lvl_q);

  ml9_deadtime #(.DT_W(DT_W)) dt_i (
    .clk_i(clk_i), .rst_i(rst_i), .fault_i(fault_i),
    .dead_cyc_i(dead_cyc_i), .target_i(sw_tgt), .gate_o(gate_o)
  );

  assign level_o = lvl_q;
endmodule

// File: rtl/ml9_pwm_chk.sv
module ml9_pwm_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       fault_i,
  input logic [7:0] gate_o,
  input logic [3:0] level_o
);
  a_r1_reset_off: assert property (@(posedge clk_i)
    rst_i |=> (gate_o == 8'h00));

  a_r8_fault_off: assert property (@(posedge clk_i) disable iff (rst_i)
    fault_i |=> (gate_o == 8'h00));

  a_r6_pair12_excl: assert property (@(posedge clk_i) disable iff (rst_i)
    !(gate_o[0] && gate_o[1]));

  a_r6_pair56_excl: assert property (@(posedge clk_i) disable iff (rst_i)
    !(gate_o[4] && gate_o[5]));

  a_r6_max_three: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(gate_o) <= 3);

  a_r7_gap_12: assert property (@(posedge clk_i) disable iff (rst_i)
    gate_o[0] |=> !gate_o[1]);

  a_r7_gap_21: assert property (@(posedge clk_i) disable iff (rst_i)
    gate_o[1] |=> !gate_o[0]);

  a_r7_gap_56: assert property (@(posedge clk_i) disable iff (rst_i)
    gate_o[4] |=> !gate_o[5]);

  a_r9_level_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_o >= 4'd1) && (level_o <= 4'd9));
endmodule

bind ml9_pwm_mod ml9_pwm_chk chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .fault_i(fault_i),
  .gate_o(gate_o), .level_o(level_o)
);

// File: tb/ml9_pwm_mod_tb.sv
module ml9_pwm_mod_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW   = 8;
  localparam int PS   = 8;
  localparam int DT_W = 3;
  localparam int BAND = (1 << SW) / 8;
  localparam int CPER = 2 * BAND * PS;

  logic clk = 1'b0;
  logic rst, fault;
  logic [DT_W-1:0] dead;
  logic [SW-1:0] smp;
  logic [7:0] gate;
  logic [3:0] lvl;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ml9_pwm_mod #(.SW(SW), .PRESCALE(PS), .DT_W(DT_W)) dut_i (
    .clk_i(clk), .rst_i(rst), .fault_i(fault), .dead_cyc_i(dead),
    .mod_i(smp), .gate_o(gate), .level_o(lvl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ref_pat(input int l);
    int on[3];
    logic [7:0] m = '0;
    case (l)
      1: on = '{2, 5, 7};
      2: on = '{2, 3, 5};
      3: on = '{2, 3, 6};
      4: on = '{2, 4, 5};
      5: on = '{1, 3, 5};
      6: on = '{1, 3, 6};
      7: on = '{1, 4, 5};
      8: on = '{1, 4, 6};
      default: on = '{1, 6, 8};
    endcase
    for (int i = 0; i < 3; i++) m[on[i]-1] = 1'b1;
    return m;
  endfunction

  function automatic int ref_level(input int u, input int t);
    int l = 1;
    for (int k = 0; k < 8; k++) if (u > k * BAND + t) l++;
    return l;
  endfunction

  // per-edge monitor
  int stable = 0, run = 0;
  bit taint = 1, f_seen = 0, r_seen = 1;
  logic [3:0] lvl_prev = 0;
  always @(negedge clk) begin
    if (!done) begin
      if (f_seen) chk(gate == 8'h00, "R8 fault clears gates", gate, 0);
      if (r_seen) chk(gate == 8'h00, "R1 reset clears gates", gate, 0);
      chk(!(gate[0] && gate[1]) && !(gate[4] && gate[5]), "R6 pair exclusion", gate, 0);
      if (lvl == lvl_prev && !f_seen && !r_seen) stable++;
      else stable = 0;
      if (stable >= int'(dead) + 3)
        chk(gate == ref_pat(lvl), "R5 level pattern", gate, ref_pat(lvl));
      if (gate[1:0] == 2'b00) begin
        run++;
        if (f_seen || r_seen) taint = 1;
      end else begin
        if (run > 0 && !taint) chk(run == int'(dead) + 1, "R7 dead gap 1/2", run, int'(dead) + 1);
        run = 0;
        taint = 0;
      end
      lvl_prev = lvl;
      f_seen = fault;
      r_seen = rst;
    end
  end

  task automatic set_cfg(input int d, input int s);
    @(posedge clk); #1 fault = 1; dead = DT_W'(d); smp = SW'(s);
    @(posedge clk); #1;
    @(posedge clk); #1 fault = 0;
    repeat (2 * CPER) @(posedge clk);
  endtask

  task automatic measure(input int u, input string req);
    int h[16];
    int e[16];
    for (int i = 0; i < 16; i++) begin h[i] = 0; e[i] = 0; end
    for (int t = 0; t <= BAND; t++) e[ref_level(u, t)] += PS;
    for (int t = BAND - 1; t >= 1; t--) e[ref_level(u, t)] += PS;
    for (int c = 0; c < CPER; c++) begin
      @(negedge clk);
      h[lvl]++;
    end
    for (int l = 1; l <= 9; l++) chk(h[l] == e[l], req, h[l], e[l]);
    chk(h[0] == 0 && h[10] == 0, "R9 level range", h[0] + h[10], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int guard;
    void'($urandom(32'd20211));
    rst = 1; fault = 0; dead = 3; smp = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(gate == 8'h00, "R1 gates in reset", gate, 0);
    chk(lvl == 4'd5, "R1 level in reset", lvl, 5);
    @(posedge clk); #1 rst = 0;

    // R7: sample between levels 4 and 5 toggles pair 1/2 each crossing
    set_cfg(3, -16);  measure(112, "R2 R3 mid 4/5");
    set_cfg(0, -128); measure(0,   "R2 bottom");
    set_cfg(4, 127);  measure(255, "R2 top");
    set_cfg(1, 0);    measure(128, "R2 centre");
    set_cfg(2, -32);  measure(96,  "R2 band edge");

    for (int it = 0; it < 8; it++) begin
      int d = $urandom % 5;
      int s = $urandom % 256;
      set_cfg(d, s);
      measure((s + 128) % 256, "R2 R3 random");
      // R8: short fault pulse during modulation
      @(posedge clk); #1 fault = 1;
      repeat (1 + $urandom % 3) @(posedge clk);
      #1 fault = 0;
      repeat (20) @(posedge clk);
    end

    // R4: sample change away from peak is ignored until the peak
    set_cfg(2, -31);
    guard = 0;
    lvl_prev_wait: begin
      logic [3:0] p = lvl;
      forever begin
        @(negedge clk);
        guard++;
        if ((p == 4'd5 && lvl == 4'd4) || guard > 4 * CPER) disable lvl_prev_wait;
        p = lvl;
      end
    end
    chk(guard <= 4 * CPER, "R4 trough found", guard, 0);
    repeat (16 * PS) @(posedge clk);
    #1 smp = 8'd127;
    for (int c = 0; c < 8 * PS; c++) begin
      @(negedge clk);
      chk(lvl == 4'd4, "R4 held before peak", lvl, 4);
    end
    repeat (2 * CPER) @(posedge clk);
    measure(255, "R4 after peak");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule